// File: doc/BRIEF.md
# Receive Idle-Wake and Break Detector

This block sits beside the character receiver of an asynchronous serial port. It watches the majority-voted receive bit and the bit-time work pulse, along with two status inputs from the receiver: whether the character state machine is idle, and whether the last frame ended with a bad stop bit. From these it keeps two sticky indications. The wake flag tells software that the line has been idle long enough. In idle-line multiprocessor mode, this marks the next frame as an address frame. The break flag tells software that the line has been held low for a long stretch after a framing error.

Each indication has its own run counter. The idle counter counts consecutive high bit times while the receiver is idle. The break counter counts consecutive low bit times while the frame-error flag is up. Both counters step only on the bit-time pulse and stop at their threshold, so one long run raises a flag only once. The receiver clears the flags by reading the data buffer or by issuing a soft reset. The wake flag also drops when the receiver leaves idle to take a new character.

Top module: `rx_line_monitor`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both flags are 0. One cycle after a soft_clr pulse, both flags are 0 and both run counters restart from zero.
- R2: While rx_idle is 1, every bit_tick with rx_bit = 1 advances the idle count. The wake flag reads 1 after the clock edge that carries the IDLE_BITS-th (default 10) consecutive such tick. Cycles without bit_tick leave the count unchanged.
- R3: A bit_tick with rx_bit = 0 while rx_idle is 1 restarts the idle count. IDLE_BITS more high ticks are then needed to set the wake flag.
- R4: With rx_idle at 0 the idle count is held at zero, so high bits never set the wake flag. A 1-to-0 change of rx_idle (a character starting) clears the wake flag on that edge.
- R5: A buf_read pulse clears the wake flag. The flag is not set again while the line stays high, because the idle count stays at its limit until a low tick or a standby exit restarts it.
- R6: With frame_err at 0 the break count is held at zero, so low bits never set the break flag.
- R7: While frame_err is 1, every bit_tick with rx_bit = 0 advances the break count. A tick with rx_bit = 1 restarts it. The break flag reads 1 after the edge carrying the BRK_BITS-th (default 10) consecutive low tick.
- R8: The break flag stays 1 after frame_err falls, until buf_read or soft_clr. After a buf_read clear it is not set again while the line stays low.
- R9: When a flag's setting event and buf_read fall in the same cycle, the flag ends up 1. soft_clr overrides any setting event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_clr | input | 1 | Soft reset of the receiver; clears flags and counters |
| bit_tick | input | 1 | One-cycle pulse per received bit time |
| rx_bit | input | 1 | Majority-voted receive bit, valid with bit_tick |
| rx_idle | input | 1 | Receiver character state machine is in standby |
| frame_err | input | 1 | Frame-error status flag of the receiver |
| buf_read | input | 1 | One-cycle strobe: receive buffer was read |
| wake_flag | output | 1 | Idle line seen; next frame is an address frame |
| break_flag | output | 1 | Break condition detected after a frame error |

## Verification
The hardest situations to reach are the ones where a counter sits at its limit and a clear arrives while the line condition persists. A flag cleared by a buffer read must stay clear even though the run goes on. The stimulus builds a run past the threshold, clears the flag, then keeps feeding the same bit value before breaking the run and building a fresh one. Sweeps over run length and over where an interrupting bit falls, inside a fixed window of ticks, compare each flag against the longest uninterrupted run, worked out arithmetically.

// File: rtl/rx_line_monitor_pkg.sv
// Package: shared types for the receive line monitor.
// Holds the flag command encoding and the priority rule that turns
// raw set/clear requests into one command.
package rx_line_monitor_pkg;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_cmd_e;

    // Priority: hard clear > set > soft clear > hold.
    function automatic flag_cmd_e pick_cmd(input logic hard_clr,
                                           input logic set_req,
                                           input logic soft_clr_req);
        if (hard_clr)          return FLAG_CLEAR;
        else if (set_req)      return FLAG_SET;
        else if (soft_clr_req) return FLAG_CLEAR;
        else                   return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/run_counter.sv
// Module: run_counter
// Counts consecutive bit-time pulses whose voted bit equals MATCH_VAL.
// Assumes: tick is a one-cycle pulse; the count saturates at LIMIT and
// reach pulses only on the step into LIMIT. Clear and !en hold it at 0.
module run_counter #(
    parameter int  LIMIT     = 10,
    parameter logic MATCH_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    input  logic bit_val,
    output logic reach
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count;
    logic          step;

    // Purpose: a counting step happens on a matching bit while enabled.
    always_comb begin
        step  = en && tick && (bit_val == MATCH_VAL);
        reach = step && (count == LAST);
    end

    // Purpose: advance, saturate or restart the run count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            count <= '0;
        end else if (tick) begin
            if (bit_val != MATCH_VAL) count <= '0;
            else if (count != TOP)    count <= count + 1'b1;
        end
    end

    // R2 / R7: the run count never passes its threshold.
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);

    // R3 / R7: a mismatching tick restarts the run.
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (bit_val != MATCH_VAL)) |=> (count == '0));
endmodule

// File: rtl/sticky_flag.sv
// Module: sticky_flag
// One status bit that holds until cleared.
// Assumes: requests are one-cycle pulses or levels sampled per edge;
// priority is resolved by the shared package function.
module sticky_flag
    import rx_line_monitor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hard_clr,
    input  logic set_req,
    input  logic soft_clr_req,
    output logic flag
);
    flag_cmd_e cmd;

    // Purpose: resolve set/clear requests into one command.
    always_comb cmd = pick_cmd(hard_clr, set_req, soft_clr_req);

    // Purpose: hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            case (cmd)
                FLAG_SET:   flag <= 1'b1;
                FLAG_CLEAR: flag <= 1'b0;
                default:    flag <= flag;
            endcase
        end
    end

    // R9: a set request that is not overridden leaves the flag high.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !hard_clr) |=> flag);
endmodule

// File: rtl/rx_line_monitor.sv
// Module: rx_line_monitor (top)
// Watches the voted receive bit and produces a sticky idle-wake flag
// and a sticky break-detect flag.
// Assumes: bit_tick is a one-cycle pulse per bit time, rx_bit is
// valid with it, and frame_err is a level held by the receiver.
module rx_line_monitor #(
    parameter int IDLE_BITS = 10,
    parameter int BRK_BITS  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic rx_idle,
    input  logic frame_err,
    input  logic buf_read,
    output logic wake_flag,
    output logic break_flag
);
    logic idle_q;
    logic char_start;
    logic idle_reach;
    logic brk_reach;

    // Purpose: remember standby so a new character start can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b0;
        else        idle_q <= rx_idle;
    end

    // Purpose: a character begins when standby is left.
    always_comb char_start = idle_q && !rx_idle;

    run_counter #(.LIMIT(IDLE_BITS), .MATCH_VAL(1'b1)) i_idle_cnt (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .en(rx_idle),
        .tick(bit_tick), .bit_val(rx_bit), .reach(idle_reach)
    );

    run_counter #(.LIMIT(BRK_BITS), .MATCH_VAL(1'b0)) i_brk_cnt (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .en(frame_err),
        .tick(bit_tick), .bit_val(rx_bit), .reach(brk_reach)
    );

    sticky_flag i_wake (
        .clk(clk), .rst_n(rst_n), .hard_clr(soft_clr),
        .set_req(idle_reach), .soft_clr_req(buf_read || char_start),
        .flag(wake_flag)
    );

    sticky_flag i_brk (
        .clk(clk), .rst_n(rst_n), .hard_clr(soft_clr),
        .set_req(brk_reach), .soft_clr_req(buf_read),
        .flag(break_flag)
    );

    // R1: soft reset leaves both flags low.
    assert_soft_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!wake_flag && !break_flag));

    // R2: wake rises only after a high tick in standby.
    assert_wake_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(rx_idle && rx_bit && bit_tick));

    // R4: leaving standby drops the wake flag.
    assert_leave_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !rx_idle) |=> !wake_flag);

    // R6 / R7: break rises only after a low tick with frame error up.
    assert_break_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_flag) |-> $past(frame_err && !rx_bit && bit_tick));

    // R8: break holds unless read or soft reset.
    assert_break_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (break_flag && !buf_read && !soft_clr) |=> break_flag);
endmodule

// File: tb/test_rx_line_monitor.sv
`timescale 1ns/1ps
module test_rx_line_monitor;
    localparam int N = 10;

    logic clk = 1'b0;
    logic rst_n, soft_clr, bit_tick, rx_bit, rx_idle, frame_err, buf_read;
    logic wake_flag, break_flag;
    int   vectors = 0;
    int   misses  = 0;
    bit   done    = 0;

    always #2.5 clk = ~clk;

    rx_line_monitor #(.IDLE_BITS(N), .BRK_BITS(N)) i_rx_line_monitor (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .bit_tick(bit_tick),
        .rx_bit(rx_bit), .rx_idle(rx_idle), .frame_err(frame_err),
        .buf_read(buf_read), .wake_flag(wake_flag), .break_flag(break_flag)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // One bit time: tick for one cycle, then one quiet cycle.
    task automatic tick(input logic b, input logic rd = 1'b0);
        rx_bit = b; bit_tick = 1'b1; buf_read = rd;
        cyc();
        bit_tick = 1'b0; buf_read = 1'b0;
        cyc();
    endtask

    task automatic ticks(input logic b, input int n);
        for (int i = 0; i < n; i++) tick(b);
    endtask

    task automatic pulse_read();
        buf_read = 1'b1; cyc(); buf_read = 1'b0; cyc();
    endtask

    task automatic pulse_soft();
        soft_clr = 1'b1; cyc(); soft_clr = 1'b0; cyc();
    endtask

    task automatic restart();
        rx_idle = 1'b0; frame_err = 1'b0; rx_bit = 1'b1;
        pulse_soft();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++; vectors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; soft_clr = 0; bit_tick = 0; rx_bit = 1; rx_idle = 0;
        frame_err = 0; buf_read = 0;
        repeat (3) cyc();
        rst_n = 1'b1; cyc();
        chk(wake_flag, 1'b0, "R1 reset wake");
        chk(break_flag, 1'b0, "R1 reset break");

        // R2: sweep run length of high ticks in standby.
        for (int n = 0; n <= 13; n++) begin
            restart(); rx_idle = 1'b1; cyc();
            ticks(1'b1, n);
            chk(wake_flag, logic'(n >= N), "R2 idle run length");
        end

        // R2: quiet cycles with a low bit do not count or restart.
        restart(); rx_idle = 1'b1; cyc();
        ticks(1'b1, N - 1);
        rx_bit = 1'b0; repeat (20) cyc();
        chk(wake_flag, 1'b0, "R2 no tick no count");
        tick(1'b1);
        chk(wake_flag, 1'b1, "R2 tick completes run");

        // R3: a low tick placed at position k within 15 ticks.
        for (int k = 0; k < 15; k++) begin
            restart(); rx_idle = 1'b1; cyc();
            for (int i = 0; i < 15; i++) tick(logic'(i != k));
            chk(wake_flag, logic'((k >= N) || (14 - k >= N)), "R3 low tick split");
        end

        // R4: outside standby highs never count.
        restart();
        ticks(1'b1, 15);
        chk(wake_flag, 1'b0, "R4 not in standby");
        rx_idle = 1'b1; cyc();
        ticks(1'b1, N);
        chk(wake_flag, 1'b1, "R4 set in standby");
        rx_idle = 1'b0; cyc();
        chk(wake_flag, 1'b0, "R4 char start clears");
        rx_idle = 1'b1; cyc();
        ticks(1'b1, N - 1);
        chk(wake_flag, 1'b0, "R4 count restarted");
        tick(1'b1);
        chk(wake_flag, 1'b1, "R4 full run again");

        // R5: read clears; no re-set while line stays high.
        pulse_read();
        chk(wake_flag, 1'b0, "R5 read clears wake");
        ticks(1'b1, 6);
        chk(wake_flag, 1'b0, "R5 saturated no re-set");
        tick(1'b0);
        ticks(1'b1, N);
        chk(wake_flag, 1'b1, "R5 new run sets");

        // R6: lows without frame error never set break.
        restart();
        ticks(1'b0, 15);
        chk(break_flag, 1'b0, "R6 no frame error");
        frame_err = 1'b1; cyc();
        ticks(1'b0, N - 1);
        chk(break_flag, 1'b0, "R6 fresh count after error");
        tick(1'b0);
        chk(break_flag, 1'b1, "R6 break after error");

        // R7: sweep low run length and position of a high tick.
        for (int n = 0; n <= 13; n++) begin
            restart(); frame_err = 1'b1; cyc();
            ticks(1'b0, n);
            chk(break_flag, logic'(n >= N), "R7 break run length");
        end
        for (int k = 0; k < 15; k++) begin
            restart(); frame_err = 1'b1; cyc();
            for (int i = 0; i < 15; i++) tick(logic'(i == k));
            chk(break_flag, logic'((k >= N) || (14 - k >= N)), "R7 high tick split");
        end

        // R8: sticky after frame error drops; read clears; no re-set.
        restart(); frame_err = 1'b1; cyc();
        ticks(1'b0, N);
        frame_err = 1'b0; repeat (4) cyc();
        chk(break_flag, 1'b1, "R8 holds after error drops");
        frame_err = 1'b1; cyc();
        ticks(1'b0, N);
        pulse_read();
        chk(break_flag, 1'b0, "R8 read clears break");
        ticks(1'b0, 6);
        chk(break_flag, 1'b0, "R8 saturated no re-set");
        tick(1'b1);
        ticks(1'b0, N);
        chk(break_flag, 1'b1, "R8 new run sets");

        // R9: set and read in same cycle -> set wins.
        restart(); rx_idle = 1'b1; cyc();
        ticks(1'b1, N - 1);
        tick(1'b1, 1'b1);
        chk(wake_flag, 1'b1, "R9 wake set beats read");
        restart(); frame_err = 1'b1; cyc();
        ticks(1'b0, N - 1);
        tick(1'b0, 1'b1);
        chk(break_flag, 1'b1, "R9 break set beats read");

        // R9: soft reset overrides a set event.
        restart(); frame_err = 1'b1; cyc();
        ticks(1'b0, N - 1);
        rx_bit = 1'b0; bit_tick = 1'b1; soft_clr = 1'b1; cyc();
        bit_tick = 1'b0; soft_clr = 1'b0; cyc();
        chk(break_flag, 1'b0, "R9 soft reset beats set");

        // R1: soft reset with both flags up; counters restart.
        restart(); rx_idle = 1'b1; cyc();
        ticks(1'b1, N);
        frame_err = 1'b1; cyc();
        ticks(1'b0, N);
        chk(wake_flag, 1'b1, "R1 pre wake");
        chk(break_flag, 1'b1, "R1 pre break");
        pulse_soft();
        chk(wake_flag, 1'b0, "R1 soft wake");
        chk(break_flag, 1'b0, "R1 soft break");
        ticks(1'b0, N - 1);
        chk(break_flag, 1'b0, "R1 break count restarted");
        tick(1'b0);
        chk(break_flag, 1'b1, "R1 break after restart");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule